// File: doc/BRIEF.md
# Prime-Module Multiaccess Memory Unit

This block is the shared data store for a SIMD array of P×Q processing elements. A ROWS×COLS array of data elements is spread over M_MOD memory modules, where M_MOD is a prime larger than P×Q. One request moves exactly P×Q elements in a single cycle, one per lane, with no two lanes landing in the same module.

A request gives a base coordinate, a shape code and a constant stride. The block finds each lane's element, then the module and in-module address of that element. Routing is a rotation: a lane is served by the module of the first element, advanced by that lane's offset modulo M_MOD. Modules that no lane needs stay idle. Rows are stored with a padded pitch of PITCH ≥ COLS words. PITCH is chosen at elaboration so that every shape with a stride that is not a multiple of M_MOD maps to distinct modules. Requests that cannot be served are rejected with an error pulse and have no effect.

Top module: `prime_multiaccess_mem`

## Requirements
- R1: While reset is asserted, and after reset with no request, rd_valid and req_err are both 0.
- R2: Shape code 0 (block): lane k holds element (row + (k/Q)·stride, col + (k%Q)·stride). Read data appears on rd_data with rd_valid high in the cycle after the request is accepted, with lane k in bits [k·DW +: DW].
- R3: Shape code 1 (row): lane k holds element (row, col + k·stride).
- R4: Shape code 2 (column): lane k holds element (row + k·stride, col).
- R5: Shape code 3 (forward diagonal): lane k holds element (row + k·stride, col + k·stride).
- R6: Shape code 4 (backward diagonal): lane k holds element (row + k·stride, col − k·stride).
- R7: A write stores all P×Q lanes of wr_data in the accepting cycle. A later read of any shape returns the stored values. A write raises neither rd_valid nor req_err.
- R8: A request that touches a coordinate outside 0..ROWS−1 or 0..COLS−1 raises req_err for one cycle in the next cycle. It raises no rd_valid and changes no stored element.
- R9: A request whose stride is a multiple of M_MOD, including zero, is rejected in the same way as R8.
- R10: Shape codes 5, 6 and 7 are rejected in the same way as R8.
- R11: A request whose last element falls exactly on the last row or column is accepted. At every accepted request, the P×Q lanes use P×Q distinct modules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Base row |
| req_col | input | $clog2(COLS) | Base column |
| req_type | input | 3 | Shape code (0 block, 1 row, 2 column, 3 forward diagonal, 4 backward diagonal) |
| req_stride | input | SW | Constant interval between elements |
| wr_data | input | P·Q·DW | Write lanes, lane k at [k·DW +: DW] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | P·Q·DW | Read lanes, lane k at [k·DW +: DW] |
| req_err | output | 1 | Previous request was rejected |

## Verification
The bench sweeps every shape over bases at the array edges and strides from 1 to 4. The bounds test must be exact: one that is too loose lets an edge-crossing request corrupt another row, and one that is too strict rejects requests that fit precisely. Strides of 0 and 5 check that strides which fold onto one module are refused; a design that accepts them would return the same value in several lanes. Writes of each shape are read back through other shapes, so a wrong rotation or lane-to-module inverse shows up as swapped or stale lanes. A wrong padded pitch shows up as module collisions.

// File: rtl/prime_multiaccess_mem.sv
module prime_multiaccess_mem #(
  parameter int P     = 2,
  parameter int Q     = 2,
  parameter int M_MOD = 5,
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int DW    = 8,
  parameter int SW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [$clog2(ROWS)-1:0] req_row,
  input  logic [$clog2(COLS)-1:0] req_col,
  input  logic [2:0]              req_type,
  input  logic [SW-1:0]           req_stride,
  input  logic [P*Q*DW-1:0]       wr_data,
  output logic                    rd_valid,
  output logic [P*Q*DW-1:0]       rd_data,
  output logic                    req_err
);

  function automatic int pitch_f();
    int w;
    logic ok, found;
    w = COLS;
    found = 1'b0;
    for (int t = 0; t < 64; t++) begin
      if (!found) begin
        ok = !((w % M_MOD == 0) || ((w + 1) % M_MOD == 0) || ((w - 1) % M_MOD == 0));
        for (int a = 0; a < P; a++)
          for (int b = 0; b < Q; b++)
            for (int a2 = 0; a2 < P; a2++)
              for (int b2 = 0; b2 < Q; b2++)
                if ((a != a2 || b != b2) && (((a - a2) * w + (b - b2)) % M_MOD == 0)) ok = 1'b0;
        if (ok) found = 1'b1;
        else w = w + 1;
      end
    end
    return w;
  endfunction

  localparam int L     = P * Q;
  localparam int PITCH = pitch_f();
  localparam int DEPTH = ((ROWS - 1) * PITCH + COLS - 1) / M_MOD + 1;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MW    = $clog2(M_MOD);
  localparam int LIW   = (L > 1) ? $clog2(L) : 1;

  logic [DW-1:0]  mem [M_MOD][DEPTH];
  logic [DW-1:0]  bank_q [M_MOD];
  logic [MW-1:0]  lane_mod [L];
  logic [MW-1:0]  lane_mod_q [L];
  logic [AW-1:0]  lane_addr [L];
  logic [M_MOD-1:0] sel;
  logic [LIW-1:0] mod_lane [M_MOD];
  logic [AW-1:0]  mod_addr [M_MOD];
  logic           bad, go;
  int             lr [L];
  int             lc [L];
  int             lin [L];

  always_comb begin
    int r0, c0, s, m0, off, md, d;
    r0 = int'(req_row);
    c0 = int'(req_col);
    s  = int'(req_stride);
    bad = (req_type > 3'd4) || (s % M_MOD == 0);
    for (int k = 0; k < L; k++) begin
      case (req_type)
        3'd0:    begin lr[k] = r0 + (k / Q) * s; lc[k] = c0 + (k % Q) * s; end
        3'd1:    begin lr[k] = r0;               lc[k] = c0 + k * s;       end
        3'd2:    begin lr[k] = r0 + k * s;       lc[k] = c0;               end
        3'd3:    begin lr[k] = r0 + k * s;       lc[k] = c0 + k * s;       end
        3'd4:    begin lr[k] = r0 + k * s;       lc[k] = c0 - k * s;       end
        default: begin lr[k] = r0;               lc[k] = c0;               end
      endcase
      if (lr[k] >= ROWS || lc[k] < 0 || lc[k] >= COLS) bad = 1'b1;
      lin[k] = lr[k] * PITCH + lc[k];
    end
    m0 = lin[0] % M_MOD;
    for (int k = 0; k < L; k++) begin
      d   = bad ? 0 : lin[k] - lin[0];
      off = d % M_MOD;
      md  = m0 + off;
      if (md >= M_MOD) md = md - M_MOD;
      lane_mod[k]  = MW'(md);
      lane_addr[k] = bad ? '0 : AW'(lin[k] / M_MOD);
    end
  end

  assign go = req_valid && !bad;

  always_comb begin
    for (int j = 0; j < M_MOD; j++) begin
      sel[j] = 1'b0;
      mod_lane[j] = '0;
      mod_addr[j] = '0;
      for (int k = 0; k < L; k++)
        if (lane_mod[k] == MW'(j)) begin
          sel[j] = go;
          mod_lane[j] = LIW'(k);
          mod_addr[j] = lane_addr[k];
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < M_MOD; j++) begin
      if (sel[j] && req_write) mem[j][mod_addr[j]] <= wr_data[int'(mod_lane[j])*DW +: DW];
      if (sel[j] && !req_write) bank_q[j] <= mem[j][mod_addr[j]];
    end
    for (int k = 0; k < L; k++) lane_mod_q[k] <= lane_mod[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      req_err  <= 1'b0;
    end else begin
      rd_valid <= go && !req_write;
      req_err  <= req_valid && bad;
    end
  end

  for (genvar k = 0; k < L; k++) begin : g_lane
    assign rd_data[k*DW +: DW] = bank_q[lane_mod_q[k]];
  end

  initial assert (M_MOD > L);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rd_valid && !req_err));
  // R2
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rd_valid != req_err));
  // R7
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rd_valid);
  // R9
  stride_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (int'(req_stride) % M_MOD == 0)) |=> req_err);
  // R10
  bad_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type > 3'd4) |=> req_err);
  // R11
  conflict_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ($countones(sel) == L));

endmodule

// File: tb/test_prime_multiaccess_mem.sv
`timescale 1ns/1ps
module test_prime_multiaccess_mem;
  localparam int P = 2, Q = 2, M_MOD = 5, ROWS = 16, COLS = 16, DW = 8, SW = 4;
  localparam int L = P * Q;

  typedef struct {
    logic          err;
    logic [L*DW-1:0] data;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [3:0] req_row = 0, req_col = 0;
  logic [2:0] req_type = 0;
  logic [SW-1:0] req_stride = 0;
  logic [L*DW-1:0] wr_data = 0;
  logic rd_valid, req_err;
  logic [L*DW-1:0] rd_data;

  logic [DW-1:0] model [ROWS][COLS];
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prime_multiaccess_mem #(.P(P), .Q(Q), .M_MOD(M_MOD), .ROWS(ROWS), .COLS(COLS), .DW(DW), .SW(SW))
  i_prime_multiaccess_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_type(req_type), .req_stride(req_stride),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data), .req_err(req_err));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input int r, input int c, input int t, input int s,
                       input logic [L*DW-1:0] wd);
    int lr[L], lc[L];
    bit legal;
    exp_t e;
    string names[5] = '{"R2 block", "R3 row", "R4 column", "R5 fwd diag", "R6 back diag"};
    legal = (t <= 4) && (s % M_MOD != 0);
    for (int k = 0; k < L; k++) begin
      case (t)
        0: begin lr[k] = r + (k / Q) * s; lc[k] = c + (k % Q) * s; end
        1: begin lr[k] = r;               lc[k] = c + k * s;       end
        2: begin lr[k] = r + k * s;       lc[k] = c;               end
        3: begin lr[k] = r + k * s;       lc[k] = c + k * s;       end
        4: begin lr[k] = r + k * s;       lc[k] = c - k * s;       end
        default: begin lr[k] = r;         lc[k] = c;               end
      endcase
      if (lr[k] < 0 || lr[k] >= ROWS || lc[k] < 0 || lc[k] >= COLS) legal = 0;
    end
    e.err = !legal;
    e.data = '0;
    if (t > 4) e.tag = "R10 bad shape";
    else if (s % M_MOD == 0) e.tag = "R9 folding stride";
    else if (!legal) e.tag = "R8 out of bounds";
    else e.tag = wr ? "R7 write" : names[t];
    if (legal)
      for (int k = 0; k < L; k++) begin
        if (wr) model[lr[k]][lc[k]] = wd[k*DW +: DW];
        else e.data[k*DW +: DW] = model[lr[k]][lc[k]];
      end
    req_valid = 1; req_write = wr;
    req_row = 4'(r); req_col = 4'(c); req_type = 3'(t); req_stride = SW'(s); wr_data = wd;
    if (!wr || !legal) q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (rd_valid || req_err)) begin
      if (q.size() == 0) begin
        check(0, "R1 unexpected output", {62'd0, rd_valid, req_err}, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(req_err == e.err && rd_valid == !e.err, {e.tag, " flags"},
              {62'd0, rd_valid, req_err}, {62'd0, !e.err, e.err});
        if (!e.err) check(rd_data == e.data, {e.tag, " data"}, 64'(rd_data), 64'(e.data));
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) model[r][c] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!rd_valid && !req_err, "R1 reset", {62'd0, rd_valid, req_err}, 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!rd_valid && !req_err, "R1 idle", {62'd0, rd_valid, req_err}, 64'd0);

    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c += L) begin
        logic [L*DW-1:0] wd;
        for (int k = 0; k < L; k++) wd[k*DW +: DW] = 8'((r * 16 + c + k) ^ 8'hA5);
        issue(1, r, c, 1, 1, wd);
      end

    // R2..R6, R8: shape sweep
    for (int t = 0; t < 5; t++)
      for (int s = 1; s <= 4; s++)
        foreach (model[r]) begin
          if (r == 0 || r == 3 || r == 9 || r == 15) begin
            issue(0, r, 0, t, s, '0);
            issue(0, r, 2, t, s, '0);
            issue(0, r, 7, t, s, '0);
            issue(0, r, 12, t, s, '0);
            issue(0, r, 15, t, s, '0);
          end
        end

    // R7 writes of several shapes, read back through others
    issue(1, 4, 4, 0, 2, 32'hDEADBEEF);
    issue(0, 4, 4, 0, 2, '0);
    issue(0, 4, 4, 1, 2, '0);
    issue(1, 0, 1, 3, 3, 32'h11223344);
    issue(0, 0, 1, 3, 3, '0);
    issue(0, 3, 0, 1, 1, '0);
    issue(1, 3, 15, 4, 4, 32'h55667788);
    issue(0, 3, 3, 1, 4, '0);
    issue(0, 7, 11, 2, 4, '0);
    issue(1, 6, 9, 2, 1, 32'h99AABBCC);
    issue(0, 6, 9, 2, 1, '0);

    // R8 out-of-bounds write leaves data unchanged
    issue(1, 2, 14, 1, 1, 32'hFFFFFFFF);
    issue(0, 2, 12, 1, 1, '0);
    issue(1, 14, 0, 2, 1, 32'hFFFFFFFF);
    issue(0, 12, 0, 2, 1, '0);
    issue(1, 13, 2, 4, 1, 32'hFFFFFFFF);
    issue(0, 13, 0, 1, 1, '0);
    // R9 folding strides
    issue(1, 0, 0, 1, 5, 32'hFFFFFFFF);
    issue(1, 0, 0, 1, 0, 32'hFFFFFFFF);
    issue(0, 0, 0, 0, 10, '0);
    issue(0, 0, 0, 1, 1, '0);
    // R10 undefined shapes
    issue(0, 0, 0, 5, 1, '0);
    issue(0, 0, 0, 6, 1, '0);
    issue(1, 0, 0, 7, 1, 32'hFFFFFFFF);
    issue(0, 0, 0, 0, 1, '0);

    // R11 requests ending exactly on the last row or column
    issue(0, 14, 14, 0, 1, '0);
    issue(0, 0, 12, 1, 1, '0);
    issue(0, 12, 15, 2, 1, '0);
    issue(0, 12, 3, 4, 1, '0);
    issue(0, 12, 12, 3, 1, '0);
    issue(0, 13, 12, 3, 1, '0);
    issue(0, 3, 15, 1, 1, '0);

    // R7 full content sweep
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c += L) issue(0, r, c, 1, 1, '0);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 missing responses", 64'(q.size()), 64'd0);
    check(!rd_valid && !req_err, "R1 idle end", {62'd0, rd_valid, req_err}, 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule